// File: doc/BRIEF.md
# DMA Remapping Translation Walker

This block turns a device memory request into a physical address. A request carries a 16-bit requester ID and a 39-bit I/O virtual address (IOVA). The walker reads a device-lookup structure in two steps. First it reads a bus-level entry that points at a per-bus table. Then it reads a device/function entry that gives the page-table root, the translation type and the address-width code. After that it walks three levels of 9-bit-indexed page tables and returns the translated address. If any step fails, it returns a fault with a reason code instead.

All table reads leave through a single 64-bit read port. The port has a valid/ready request channel and a response strobe, and only one read is outstanding at a time. The walker takes one translation at a time. It is ready only when idle and signals busy until the result comes out. A page-table entry at the top or middle level may stop the walk early and map a 1 GB or 2 MB page. A per-device flag can keep faults from raising the fault-report strobe. Such faults are still blocked and still reported on the result port.

Top module: `dmar_walker`

## Requirements
- R1: The bus-level table base is `root_base_i` with its low 12 bits cleared. The first read of every request goes to that base plus 16 times the requester ID bits 15:8.
- R2: If bit 0 of the bus-level entry is 0, the request ends with a fault of reason 1 and no other read is issued. Otherwise bits 63:12 of that entry give the per-bus table page.
- R3: The device entry sits at the per-bus table page plus 16 times requester ID bits 7:0. Its upper word (+8) is read first and its lower word (+0) second. If lower-word bit 0 is 0, the result is a fault of reason 2.
- R4: If a present device entry has lower-word bits 3:2 not equal to 0, the result is a fault of reason 3.
- R5: If a present device entry of valid type has upper-word bits 2:0 (the width code) not equal to 1, the result is a fault of reason 4.
- R6: The page walk starts at lower-word bits 63:12 of the device entry. At each level it reads the table plus 8 times the index, using IOVA bits 38:30, then 29:21, then 20:12. A successful 4 KB result is PTE bits 63:12 joined with IOVA bits 11:0. A successful result has reason 0 and fault low, and a fault always has an all-zero address.
- R7: A page-table entry whose permission bits 1:0 are both 0, at any level, ends the request with a fault of reason 5.
- R8: Bit 7 set in a permitted entry at the top level gives a 1 GB page: entry bits 63:30 joined with IOVA bits 29:0. At the middle level it gives a 2 MB page: entry bits 63:21 joined with IOVA bits 20:0. At the last level bit 7 is ignored.
- R9: Lower-word bit 1 of a present device entry keeps `fault_strobe_o` low for faults of reason 3, 4 and 5, while the fault itself is still returned. Faults of reason 1 and 2 always raise the strobe. The strobe is high only together with a faulting result.
- R10: `req_ready_o` is high only when idle. `busy_o` is high from the cycle after acceptance until the result, and low in the result cycle. The result is a one-cycle `res_valid_o` pulse, one clock after the final read response.
- R11: A read request held without ready keeps the same address until accepted. While any read is issued the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base_i | input | 64 | Bus-level table base (low 12 bits ignored) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_rid_i | input | 16 | Requester ID (bus in 15:8, device/function in 7:0) |
| req_iova_i | input | 39 | I/O virtual address |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Table read request accepted |
| mem_req_addr_o | output | 64 | Table read byte address |
| mem_rsp_valid_i | input | 1 | Table read data strobe |
| mem_rsp_data_i | input | 64 | Table read data |
| res_valid_o | output | 1 | Result pulse |
| res_fault_o | output | 1 | Result is a fault |
| res_reason_o | output | 3 | 0 ok, 1 bus entry absent, 2 device entry absent, 3 bad type, 4 bad width, 5 no permission |
| res_addr_o | output | 64 | Translated physical address (zero on fault) |
| fault_strobe_o | output | 1 | Reportable fault indication |
| busy_o | output | 1 | Translation in progress |

## Verification
A result is due exactly one clock after the memory response that settles it. That is one response after acceptance for an absent bus entry, three for a failing device entry, and up to six for a full walk. Read-request ready and response latency (one to three cycles) are randomized. The bench samples every output one time unit after the falling edge. It records the falling-edge count at which it drove each response, and it requires the result pulse at the very next falling edge and gone at the one after. Busy is checked on the first falling edge after acceptance, and idle/ready in the result cycle.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ROOT   = 3'd1,
        ST_CTX_HI = 3'd2,
        ST_CTX_LO = 3'd3,
        ST_PTE    = 3'd4
    } walk_state_e;

    typedef enum logic [2:0] {
        RSN_NONE      = 3'd0,
        RSN_BUS_ABS   = 3'd1,
        RSN_DEV_ABS   = 3'd2,
        RSN_BAD_TYPE  = 3'd3,
        RSN_BAD_WIDTH = 3'd4,
        RSN_NO_PERM   = 3'd5
    } reason_e;

endpackage

// File: rtl/dmar_addr_gen.sv
module dmar_addr_gen
    import dmar_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int IOVA_W     = 39,
    parameter int LEVELS     = 3,
    parameter int IDX_W      = 9,
    parameter int PAGE_SHIFT = 12,
    parameter int LVL_W      = 2
) (
    input  walk_state_e       st,
    input  logic [ADDR_W-1:0] root_base,
    input  logic [15:0]       rid,
    input  logic [IOVA_W-1:0] iova,
    input  logic [ADDR_W-1:0] tbl,
    input  logic [LVL_W-1:0]  lvl,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] PG_MASK   = ADDR_W'((65'd1 << PAGE_SHIFT) - 65'd1);
    localparam int                WIDE_SH   = 4;   // 16-byte device-lookup entries
    localparam int                PTE_SH    = 3;   // 8-byte page-table entries
    localparam logic [ADDR_W-1:0] UPPER_OFF = ADDR_W'(8);

    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] bus_off, dev_off, pte_off;

    always_comb begin
        idx = '0;
        for (int l = 1; l <= LEVELS; l++) begin
            if (lvl == LVL_W'(l)) idx = iova[PAGE_SHIFT + (l-1)*IDX_W +: IDX_W];
        end
    end

    assign bus_off = ADDR_W'(rid[15:8]) << WIDE_SH;
    assign dev_off = ADDR_W'(rid[7:0])  << WIDE_SH;
    assign pte_off = ADDR_W'(idx)       << PTE_SH;

    always_comb begin
        unique case (st)
            ST_ROOT:   addr = (root_base & ~PG_MASK) + bus_off;
            ST_CTX_HI: addr = tbl + dev_off + UPPER_OFF;
            ST_CTX_LO: addr = tbl + dev_off;
            ST_PTE:    addr = tbl + pte_off;
            default:   addr = '0;
        endcase
    end
endmodule

// File: rtl/dmar_pte_eval.sv
module dmar_pte_eval #(
    parameter int ADDR_W     = 64,
    parameter int IOVA_W     = 39,
    parameter int LEVELS     = 3,
    parameter int IDX_W      = 9,
    parameter int PAGE_SHIFT = 12,
    parameter int LVL_W      = 2,
    parameter int LARGE_BIT  = 7
) (
    input  logic [ADDR_W-1:0] ent,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [IOVA_W-1:0] iova,
    output logic              perm_ok,
    output logic              leaf,
    output logic [ADDR_W-1:0] next_tbl,
    output logic [ADDR_W-1:0] leaf_pa
);
    logic [LEVELS-1:0][ADDR_W-1:0] off_mask;
    logic [ADDR_W-1:0]             sel_mask;

    for (genvar g = 0; g < LEVELS; g++) begin : g_mask
        assign off_mask[g] = ADDR_W'((65'd1 << (PAGE_SHIFT + g*IDX_W)) - 65'd1);
    end

    always_comb begin
        leaf     = 1'b0;
        sel_mask = off_mask[0];
        for (int l = 1; l <= LEVELS; l++) begin
            if (lvl == LVL_W'(l) && (l == 1 || ent[LARGE_BIT])) begin
                leaf     = 1'b1;
                sel_mask = off_mask[l-1];
            end
        end
    end

    assign perm_ok  = |ent[1:0];
    assign next_tbl = ent & ~off_mask[0];
    assign leaf_pa  = (ent & ~sel_mask) | (ADDR_W'(iova) & sel_mask);
endmodule

// File: rtl/dmar_walker.sv
module dmar_walker
    import dmar_pkg::*;
#(
    parameter int          ADDR_W     = 64,
    parameter int          IOVA_W     = 39,
    parameter int          LEVELS     = 3,
    parameter int          IDX_W      = 9,
    parameter int          PAGE_SHIFT = 12,
    parameter logic [2:0]  WIDTH_CODE = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [15:0]       req_rid_i,
    input  logic [IOVA_W-1:0] req_iova_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [ADDR_W-1:0] mem_rsp_data_i,
    output logic              res_valid_o,
    output logic              res_fault_o,
    output logic [2:0]        res_reason_o,
    output logic [ADDR_W-1:0] res_addr_o,
    output logic              fault_strobe_o,
    output logic              busy_o
);
    localparam int LVL_W = $clog2(LEVELS + 1);

    typedef struct packed {
        walk_state_e       st;
        logic              pend;
        logic [15:0]       rid;
        logic [IOVA_W-1:0] iova;
        logic [ADDR_W-1:0] tbl;
        logic [LVL_W-1:0]  lvl;
        logic [2:0]        wcode;
        logic              quiet;
        logic              res_v;
        logic              res_f;
        logic              res_stb;
        reason_e           rsn;
        logic [ADDR_W-1:0] pa;
    } walk_t;

    walk_t q, d;

    logic              perm_ok, leaf;
    logic [ADDR_W-1:0] next_tbl, leaf_pa;

    dmar_addr_gen #(
        .ADDR_W(ADDR_W), .IOVA_W(IOVA_W), .LEVELS(LEVELS),
        .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .LVL_W(LVL_W)
    ) u_agen (
        .st(q.st), .root_base(root_base_i), .rid(q.rid), .iova(q.iova),
        .tbl(q.tbl), .lvl(q.lvl), .addr(mem_req_addr_o)
    );

    dmar_pte_eval #(
        .ADDR_W(ADDR_W), .IOVA_W(IOVA_W), .LEVELS(LEVELS),
        .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .LVL_W(LVL_W)
    ) u_eval (
        .ent(mem_rsp_data_i), .lvl(q.lvl), .iova(q.iova),
        .perm_ok(perm_ok), .leaf(leaf), .next_tbl(next_tbl), .leaf_pa(leaf_pa)
    );

    function automatic walk_t finish(walk_t s, reason_e r, logic silent, logic [ADDR_W-1:0] pa);
        walk_t o;
        o         = s;
        o.st      = ST_IDLE;
        o.pend    = 1'b0;
        o.res_v   = 1'b1;
        o.res_f   = (r != RSN_NONE);
        o.rsn     = r;
        o.pa      = (r != RSN_NONE) ? '0 : pa;
        o.res_stb = (r != RSN_NONE) && !silent;
        return o;
    endfunction

    logic rsp_here;

    always_comb begin
        d         = q;
        d.res_v   = 1'b0;
        d.res_stb = 1'b0;
        mem_req_valid_o = (q.st != ST_IDLE) && !q.pend;
        rsp_here        = q.pend && mem_rsp_valid_i;
        if (mem_req_valid_o && mem_req_ready_i) d.pend = 1'b1;
        if (rsp_here) d.pend = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.st    = ST_ROOT;
                    d.rid   = req_rid_i;
                    d.iova  = req_iova_i;
                    d.pend  = 1'b0;
                    d.quiet = 1'b0;
                end
            end
            ST_ROOT: begin
                if (rsp_here) begin
                    if (!mem_rsp_data_i[0]) d = finish(d, RSN_BUS_ABS, 1'b0, '0);
                    else begin
                        d.tbl = next_tbl;
                        d.st  = ST_CTX_HI;
                    end
                end
            end
            ST_CTX_HI: begin
                if (rsp_here) begin
                    d.wcode = mem_rsp_data_i[2:0];
                    d.st    = ST_CTX_LO;
                end
            end
            ST_CTX_LO: begin
                if (rsp_here) begin
                    if (!mem_rsp_data_i[0])
                        d = finish(d, RSN_DEV_ABS, 1'b0, '0);
                    else if (mem_rsp_data_i[3:2] != 2'b00)
                        d = finish(d, RSN_BAD_TYPE, mem_rsp_data_i[1], '0);
                    else if (q.wcode != WIDTH_CODE)
                        d = finish(d, RSN_BAD_WIDTH, mem_rsp_data_i[1], '0);
                    else begin
                        d.quiet = mem_rsp_data_i[1];
                        d.tbl   = next_tbl;
                        d.lvl   = LVL_W'(LEVELS);
                        d.st    = ST_PTE;
                    end
                end
            end
            ST_PTE: begin
                if (rsp_here) begin
                    if (!perm_ok)  d = finish(d, RSN_NO_PERM, q.quiet, '0);
                    else if (leaf) d = finish(d, RSN_NONE, q.quiet, leaf_pa);
                    else begin
                        d.tbl = next_tbl;
                        d.lvl = q.lvl - LVL_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready_o    = (q.st == ST_IDLE);
    assign busy_o         = (q.st != ST_IDLE);
    assign res_valid_o    = q.res_v;
    assign res_fault_o    = q.res_f;
    assign res_reason_o   = q.rsn;
    assign res_addr_o     = q.pa;
    assign fault_strobe_o = q.res_stb;
endmodule

// File: rtl/dmar_walker_chk.sv
module dmar_walker_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              busy_o,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic [ADDR_W-1:0] mem_req_addr_o,
    input logic              res_valid_o,
    input logic              res_fault_o,
    input logic [2:0]        res_reason_o,
    input logic [ADDR_W-1:0] res_addr_o,
    input logic              fault_strobe_o
);
    assert_hold_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    assert_read_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> busy_o);

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o |=> busy_o);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !req_ready_o);

    assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    assert_strobe_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_strobe_o |-> res_valid_o && res_fault_o);

    assert_fault_noaddr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && res_fault_o |-> res_addr_o == '0 && res_reason_o != 3'd0);

    assert_ok_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && !res_fault_o |-> res_reason_o == 3'd0);
endmodule

bind dmar_walker dmar_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .busy_o(busy_o), .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .res_valid_o(res_valid_o), .res_fault_o(res_fault_o),
    .res_reason_o(res_reason_o), .res_addr_o(res_addr_o), .fault_strobe_o(fault_strobe_o)
);

// File: tb/sim_dmar_walker.sv
`timescale 1ns/1ps
module sim_dmar_walker;
    localparam logic [63:0] ROOT_B = 64'h0000_0000_0001_0000;
    localparam logic [63:0] PGM    = 64'hFFFF_FFFF_FFFF_F000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] root_base;
    logic        req_valid, req_ready;
    logic [15:0] req_rid;
    logic [38:0] req_iova;
    logic        mem_req_valid, mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        res_valid, res_fault, fault_strobe, busy;
    logic [2:0]  res_reason;
    logic [63:0] res_addr;

    dmar_walker u0 (
        .clk(clk), .rst_n(rst_n), .root_base_i(root_base),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_rid_i(req_rid), .req_iova_i(req_iova),
        .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_req_addr_o(mem_req_addr),
        .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
        .res_valid_o(res_valid), .res_fault_o(res_fault), .res_reason_o(res_reason),
        .res_addr_o(res_addr), .fault_strobe_o(fault_strobe), .busy_o(busy)
    );

    initial forever #2.5 clk = ~clk;

    int compared = 0, mismatched = 0;
    bit summary_done = 0;

    logic [63:0] mem [logic [63:0]];
    int          cyc = 0, last_rsp_cyc = -10, rd_count = 0, lat = 0;
    logic [63:0] hs_addr, first_addr;

    function automatic logic [63:0] rd(logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: random ready, latency 1..3 falling edges
    initial begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(hs_addr);
                    last_rsp_cyc  = cyc;
                end
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (rst_n && mem_req_valid && mem_req_ready && lat == 0) begin
                hs_addr = mem_req_addr;
                if (rd_count == 0) first_addr = mem_req_addr;
                rd_count++;
                lat = 1 + int'($urandom % 3);
            end
        end
    end

    // reference walk, from the requirements
    function automatic void ref_walk(input logic [63:0] rb, input logic [15:0] rid, input logic [38:0] iova,
                                     output bit f, output logic [2:0] rsn, output logic [63:0] pa,
                                     output bit stb, output int nrd, output logic [63:0] a0);
        logic [63:0] re, lo, hi, t, e;
        int sh;
        f = 1; pa = 0; stb = 1; rsn = 0;
        a0  = (rb & PGM) + 64'(rid[15:8]) * 16;
        re  = rd(a0); nrd = 1;
        if (!re[0]) begin rsn = 1; return; end
        hi = rd((re & PGM) + 64'(rid[7:0]) * 16 + 8);
        lo = rd((re & PGM) + 64'(rid[7:0]) * 16);
        nrd = 3;
        if (!lo[0]) begin rsn = 2; return; end
        stb = !lo[1];
        if (lo[3:2] != 0)   begin rsn = 3; return; end
        if (hi[2:0] != 1)   begin rsn = 4; return; end
        t = lo & PGM;
        for (int l = 3; l >= 1; l--) begin
            e = rd(t + 64'(iova[12 + (l-1)*9 +: 9]) * 8);
            nrd++;
            if (e[1:0] == 0) begin rsn = 5; return; end
            if (l == 1 || e[7]) begin
                sh  = 12 + (l-1)*9;
                pa  = ((e >> sh) << sh) | (64'(iova) & ((64'd1 << sh) - 1));
                f   = 0; stb = 0;
                return;
            end
            t = e & PGM;
        end
    endfunction

    function automatic logic [63:0] rnd_page();
        return {$urandom, $urandom} & 64'h0000_00FF_FFFF_F000;
    endfunction

    task automatic build(int k, logic [15:0] rid, logic [38:0] iova, bit rp, bit cp, logic [1:0] tt,
                         bit fpd, logic [2:0] aw, logic [1:0] p3, bit l3, logic [1:0] p2, bit l2,
                         logic [1:0] p1, bit l1);
        logic [63:0] ctp, slpt, t2, t1, ra, ca;
        ctp  = 64'h0100_0000 + 64'(k) * 64'h1_0000;
        slpt = ctp + 64'h1000; t2 = ctp + 64'h2000; t1 = ctp + 64'h3000;
        ra = ROOT_B + 64'(rid[15:8]) * 16;
        mem[ra]     = ctp | 64'(rp);
        mem[ra + 8] = {$urandom, $urandom};
        ca = ctp + 64'(rid[7:0]) * 16;
        mem[ca]     = slpt | (64'(tt) << 2) | (64'(fpd) << 1) | 64'(cp);
        mem[ca + 8] = (64'($urandom) << 24) | (64'(rid) << 8) | 64'(aw);
        mem[slpt + 64'(iova[38:30]) * 8] = (l3 ? rnd_page() : t2) | (64'(l3) << 7) | 64'(p3);
        mem[t2   + 64'(iova[29:21]) * 8] = (l2 ? rnd_page() : t1) | (64'(l2) << 7) | 64'(p2);
        mem[t1   + 64'(iova[20:12]) * 8] = rnd_page() | (64'(l1) << 7) | 64'(p1);
    endtask

    task automatic run_one(string req, logic [15:0] rid, logic [38:0] iova);
        bit ef, es; logic [2:0] er; logic [63:0] ea, e0; int en, n;
        ref_walk(root_base, rid, iova, ef, er, ea, es, en, e0);
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R10", "ready when idle", 64'(req_ready), 64'd1);
        rd_count = 0;
        req_valid = 1'b1; req_rid = rid; req_iova = iova;
        @(negedge clk); #1;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", 64'(busy), 64'd1);
        n = 0;
        while (!res_valid && n < 5000) begin @(negedge clk); #1; n++; end
        chk(res_valid == 1'b1, "R10", "result arrives", 64'(res_valid), 64'd1);
        chk(cyc == last_rsp_cyc + 1, "R10", "result one clock after last response",
            64'(cyc), 64'(last_rsp_cyc + 1));
        chk(!busy && req_ready, "R10", "idle in result cycle", 64'(busy), 64'd0);
        chk(res_fault == ef, req, "fault flag", 64'(res_fault), 64'(ef));
        chk(res_reason == er, req, "reason code", 64'(res_reason), 64'(er));
        chk(res_addr == ea, req, "translated address", res_addr, ea);
        chk(fault_strobe == es, req, "fault strobe (R9)", 64'(fault_strobe), 64'(es));
        chk(rd_count == en, req, "table reads issued", 64'(rd_count), 64'(en));
        chk(first_addr == e0, "R1", "first read address", first_addr, e0);
        @(negedge clk); #1;
        chk(res_valid == 1'b0, "R10", "single result pulse", 64'(res_valid), 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!summary_done) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual hung expected done");
            summary_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int k;
        logic [15:0] rid; logic [38:0] iova;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; root_base = ROOT_B; req_valid = 1'b0; req_rid = '0; req_iova = '0;
        repeat (4) @(negedge clk);
        #1;
        chk(!res_valid && !busy && !mem_req_valid && !fault_strobe, "R10", "reset state",
            {60'd0, res_valid, busy, mem_req_valid, fault_strobe}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 64'd1);

        k = 0;
        // R1: junk in low base bits, full 4 KB walk (R6)
        root_base = ROOT_B | 64'hABC;
        rid = 16'h3A17; iova = 39'h12_3456_789A;
        build(k++, rid, iova, 1, 1, 0, 0, 1, 3, 0, 3, 0, 3, 0); run_one("R1", rid, iova);
        run_one("R6", rid, iova);
        root_base = ROOT_B;
        rid = 16'h0102; iova = 39'h7F_FFFF_FFFF;
        build(k++, rid, iova, 0, 1, 0, 0, 1, 3, 0, 3, 0, 3, 0); run_one("R2", rid, iova);
        build(k++, rid, iova, 1, 0, 0, 1, 1, 3, 0, 3, 0, 3, 0); run_one("R3", rid, iova);
        build(k++, rid, iova, 1, 1, 2, 0, 1, 3, 0, 3, 0, 3, 0); run_one("R4", rid, iova);
        build(k++, rid, iova, 1, 1, 0, 0, 2, 3, 0, 3, 0, 3, 0); run_one("R5", rid, iova);
        build(k++, rid, iova, 1, 1, 0, 0, 1, 1, 0, 0, 0, 3, 0); run_one("R7", rid, iova);
        rid = 16'hFFFF; iova = 39'h55_5555_5555;
        build(k++, rid, iova, 1, 1, 0, 0, 1, 2, 1, 3, 0, 3, 0); run_one("R8", rid, iova);
        build(k++, rid, iova, 1, 1, 0, 0, 1, 3, 0, 1, 1, 3, 0); run_one("R8", rid, iova);
        build(k++, rid, iova, 1, 1, 0, 0, 1, 3, 0, 3, 0, 2, 1); run_one("R8", rid, iova);
        build(k++, rid, iova, 1, 1, 0, 1, 1, 3, 0, 3, 0, 0, 0); run_one("R9", rid, iova);
        build(k++, rid, iova, 1, 1, 1, 1, 1, 3, 0, 3, 0, 3, 0); run_one("R9", rid, iova);
        build(k++, rid, iova, 1, 0, 3, 1, 5, 3, 0, 3, 0, 3, 0); run_one("R3", rid, iova);

        // constrained random mix
        for (int t = 0; t < 200; t++) begin
            logic [1:0] tt; logic [2:0] aw;
            rid  = 16'($urandom);
            iova = {7'($urandom), $urandom};
            tt   = ($urandom % 10 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
            aw   = ($urandom % 10 == 0) ? 3'(2 + $urandom % 6) : 3'd1;
            root_base = ROOT_B | 64'($urandom % 4096);
            build(k++, rid, iova, ($urandom % 16) != 0, ($urandom % 16) != 0, tt, 1'($urandom),
                  aw, ($urandom % 10 == 0) ? 2'd0 : 2'(1 + $urandom % 3), ($urandom % 8) == 0,
                  ($urandom % 10 == 0) ? 2'd0 : 2'(1 + $urandom % 3), ($urandom % 6) == 0,
                  ($urandom % 10 == 0) ? 2'd0 : 2'(1 + $urandom % 3), 1'($urandom));
            run_one("R6", rid, iova);
        end

        if (!summary_done) begin
            summary_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        end
        $finish;
    end
endmodule